// File: doc/BRIEF.md
# SRAM Bus Timing Monitor

A passive observer for an asynchronous byte-wide static RAM bus with 17 address bits. It samples the two chip selects (one active low, one active high), the output enable, the write enable, the address and the data lines on every edge of a fast sampling clock. From these samples it rebuilds the bus mode and each read and write cycle. It drives nothing on the bus. All time intervals are counted in sampling clock periods and compared against parameterised minimum thresholds.

A write window is open only while all three write qualifiers agree: active-low select low, active-high select high and write enable low. The window opens on whichever of these arrives last and closes on whichever leaves first. At the close, the monitor checks the window length, the time since the selects became active, the time since the address last changed and the time since the data last changed. Between cycles it checks the spacing of address changes, and it flags any address movement inside an open window. Each broken rule sets a sticky flag. A one-cycle strobe reports the broken rule with a code, and a counter counts the completed cycles.

Top module: `sram_bus_monitor`

## Requirements
- R1: After reset, all violation flags, the strobe and the cycle counter are zero.
- R2: The write window opens on the latest of: active-low select falling, active-high select rising, write enable falling. It closes on the earliest opposite edge. If the window lasts fewer than T_WP samples (default 5), flag bit 0 sets.
- R3: At window close, if fewer than T_CW samples (default 6) have passed since both selects became active, flag bit 1 sets.
- R4: At window close, if fewer than T_AW samples (default 6) have passed since the last address change, flag bit 2 sets. This includes a change in the closing sample itself.
- R5: At window close, if fewer than T_DW samples (default 3) have passed since the last data change, flag bit 3 sets.
- R6: Flag bit 4 sets when two address changes happen fewer than T_CYC samples (default 7) apart. Both selects must be active at both changes, with no deselection in between. A deselection removes the earlier change from the comparison.
- R7: An address change seen while the write window was open in both the current and the previous sample sets flag bit 5.
- R8: The strobe is high for one sample cycle in each cycle that breaks at least one rule. Its 3-bit code is the lowest flag index broken in that cycle (0 to 5 as in R2 to R7).
- R9: Flags stay set until the clear input is high at a clock edge. A violation recorded at the same edge as the clear is kept, and all other flags are cleared.
- R10: The cycle counter adds one for each write window close. It also adds one for each address change in read mode, meaning both selects active, output enable low and write enable high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Active-low reset |
| clr | input | 1 | Clears the sticky flags |
| bus_sel_n | input | 1 | Active-low chip select pin |
| bus_sel | input | 1 | Active-high chip select pin |
| bus_oe_n | input | 1 | Active-low output enable pin |
| bus_we_n | input | 1 | Active-low write enable pin |
| bus_addr | input | ADDR_W | Address pins |
| bus_data | input | DATA_W | Data pins |
| flags | output | 6 | Sticky violation flags, bit index as in R2 to R7 |
| flag_stb | output | 1 | One-cycle violation strobe |
| flag_code | output | 3 | Lowest rule index broken in the strobe cycle |
| cycles | output | CYC_W | Completed cycle counter |

## Verification
Two things can land in the same sample cycle. First, a window close can break several end-of-write rules at once. The bench sweeps window length, select lead, address lead and data lead together, and it requires one strobe carrying the lowest broken index while every broken rule's flag is set. Second, a clear can arrive at the edge that records a new violation. The bench raises the clear one cycle after the window closes and expects the close-time rules to survive, while an earlier address-during-write flag from the same write is removed.

// File: rtl/smon_pkg.sv
package smon_pkg;

   typedef enum logic [1:0] {
      MODE_OFF   = 2'd0,
      MODE_IDLE  = 2'd1,
      MODE_READ  = 2'd2,
      MODE_WRITE = 2'd3
   } bus_mode_e;

   localparam int NRULE   = 6;
   localparam int CODE_W  = 3;
   localparam int RULE_WP  = 0;
   localparam int RULE_CW  = 1;
   localparam int RULE_AW  = 2;
   localparam int RULE_DW  = 3;
   localparam int RULE_CYC = 4;
   localparam int RULE_AWR = 5;

   localparam int NTMR    = 4;
   localparam int TMR_WIN = 0;
   localparam int TMR_SEL = 1;
   localparam int TMR_ADR = 2;
   localparam int TMR_DAT = 3;

endpackage

// File: rtl/smon_decode.sv
module smon_decode
   import smon_pkg::*;
#(
   parameter int ADDR_W = 17,
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              pin_sel_n,
   input  logic              pin_sel,
   input  logic              pin_oe_n,
   input  logic              pin_we_n,
   input  logic [ADDR_W-1:0] pin_addr,
   input  logic [DATA_W-1:0] pin_data,
   output logic              sel_now,
   output logic              sel_rise,
   output logic              read_now,
   output logic              win_start,
   output logic              win_end,
   output logic              win_hold,
   output logic              addr_chg,
   output logic              data_chg
);

   typedef struct packed {
      logic              sel_n;
      logic              sel;
      logic              oe_n;
      logic              we_n;
      logic [ADDR_W-1:0] addr;
      logic [DATA_W-1:0] data;
   } smp_t;

   localparam smp_t IDLE_SMP = '{sel_n: 1'b1, sel: 1'b0, oe_n: 1'b1, we_n: 1'b1,
                                 addr: '0, data: '0};

   smp_t cur_q, prv_q;
   bus_mode_e mode_c, mode_p;

   function automatic bus_mode_e decode(input smp_t s);
      if (s.sel_n || !s.sel)  return MODE_OFF;
      else if (!s.we_n)       return MODE_WRITE;
      else if (!s.oe_n)       return MODE_READ;
      else                    return MODE_IDLE;
   endfunction

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cur_q <= IDLE_SMP;
         prv_q <= IDLE_SMP;
      end else begin
         cur_q <= '{sel_n: pin_sel_n, sel: pin_sel, oe_n: pin_oe_n, we_n: pin_we_n,
                    addr: pin_addr, data: pin_data};
         prv_q <= cur_q;
      end
   end

   always_comb begin
      mode_c    = decode(cur_q);
      mode_p    = decode(prv_q);
      sel_now   = (mode_c != MODE_OFF);
      sel_rise  = sel_now && (mode_p == MODE_OFF);
      read_now  = (mode_c == MODE_READ);
      win_start = (mode_c == MODE_WRITE) && (mode_p != MODE_WRITE);
      win_end   = (mode_c != MODE_WRITE) && (mode_p == MODE_WRITE);
      win_hold  = (mode_c == MODE_WRITE) && (mode_p == MODE_WRITE);
      addr_chg  = (cur_q.addr != prv_q.addr);
      data_chg  = (cur_q.data != prv_q.data);
   end

   assert_win_edges_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !(win_start && win_end));

   assert_win_needs_sel_R2: assert property (@(posedge clk) disable iff (!rst_n)
      win_start |-> sel_now);

endmodule

// File: rtl/smon_timer.sv
module smon_timer #(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             restart,
   output logic [CNT_W-1:0] cnt
);

   localparam logic [CNT_W-1:0] CNT_MAX = '1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              cnt <= CNT_MAX;
      else if (restart)        cnt <= '0;
      else if (cnt != CNT_MAX) cnt <= cnt + 1'b1;
   end

   assert_tmr_sat_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt == CNT_MAX && !restart) |=> (cnt == CNT_MAX));

   assert_tmr_restart_R4: assert property (@(posedge clk) disable iff (!rst_n)
      restart |=> (cnt == '0));

endmodule

// File: rtl/smon_flags.sv
module smon_flags #(
   parameter int NR     = 6,
   parameter int CODE_W = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic [NR-1:0]     hit,
   output logic [NR-1:0]     viol,
   output logic              stb,
   output logic [CODE_W-1:0] code
);

   logic [CODE_W-1:0] code_n;

   generate
      if ((1 << CODE_W) < NR) begin : g_bad_code
         $error("smon_flags: CODE_W too narrow for NR");
      end
   endgenerate

   always_comb begin
      code_n = '0;
      for (int i = NR - 1; i >= 0; i--) begin
         if (hit[i]) code_n = CODE_W'(i);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         viol <= '0;
         stb  <= 1'b0;
         code <= '0;
      end else begin
         viol <= clr ? hit : (viol | hit);
         stb  <= |hit;
         code <= (|hit) ? code_n : code;
      end
   end

   assert_stb_code_R8: assert property (@(posedge clk) disable iff (!rst_n)
      stb |-> viol[code]);

   assert_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !clr |=> ((viol & $past(viol)) == $past(viol)));

   assert_stb_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (hit == '0) |=> !stb);

endmodule

// File: rtl/sram_bus_monitor.sv
module sram_bus_monitor
   import smon_pkg::*;
#(
   parameter int ADDR_W = 17,
   parameter int DATA_W = 8,
   parameter int CNT_W  = 8,
   parameter int CYC_W  = 16,
   parameter int T_WP   = 5,
   parameter int T_CW   = 6,
   parameter int T_AW   = 6,
   parameter int T_DW   = 3,
   parameter int T_CYC  = 7
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              bus_sel_n,
   input  logic              bus_sel,
   input  logic              bus_oe_n,
   input  logic              bus_we_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_data,
   output logic [5:0]        flags,
   output logic              flag_stb,
   output logic [2:0]        flag_code,
   output logic [CYC_W-1:0]  cycles
);

   localparam int LIM_MAX = (1 << CNT_W) - 1;
   localparam logic [CNT_W-1:0] L_WP  = CNT_W'(T_WP - 1);
   localparam logic [CNT_W-1:0] L_CW  = CNT_W'(T_CW - 1);
   localparam logic [CNT_W-1:0] L_AW  = CNT_W'(T_AW - 1);
   localparam logic [CNT_W-1:0] L_DW  = CNT_W'(T_DW - 1);
   localparam logic [CNT_W-1:0] L_CYC = CNT_W'(T_CYC - 1);

   generate
      if (T_WP < 1 || T_WP > LIM_MAX || T_CW < 1 || T_CW > LIM_MAX ||
          T_AW < 1 || T_AW > LIM_MAX || T_DW < 1 || T_DW > LIM_MAX ||
          T_CYC < 1 || T_CYC > LIM_MAX) begin : g_bad_lim
         $error("sram_bus_monitor: a threshold does not fit CNT_W");
      end
      if (ADDR_W < 1 || DATA_W < 1 || CYC_W < 2) begin : g_bad_width
         $error("sram_bus_monitor: bad width parameter");
      end
   endgenerate

   logic sel_now, sel_rise, read_now;
   logic win_start, win_end, win_hold, addr_chg, data_chg;
   logic armed_q;
   logic [NRULE-1:0] hit;
   logic [NTMR-1:0]  tmr_rst;
   logic [CNT_W-1:0] tcnt [NTMR];

   smon_decode #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dec (
      .clk(clk), .rst_n(rst_n),
      .pin_sel_n(bus_sel_n), .pin_sel(bus_sel), .pin_oe_n(bus_oe_n),
      .pin_we_n(bus_we_n), .pin_addr(bus_addr), .pin_data(bus_data),
      .sel_now(sel_now), .sel_rise(sel_rise), .read_now(read_now),
      .win_start(win_start), .win_end(win_end), .win_hold(win_hold),
      .addr_chg(addr_chg), .data_chg(data_chg)
   );

   always_comb begin
      tmr_rst          = '0;
      tmr_rst[TMR_WIN] = win_start;
      tmr_rst[TMR_SEL] = sel_rise;
      tmr_rst[TMR_ADR] = addr_chg;
      tmr_rst[TMR_DAT] = data_chg;
   end

   generate
      for (genvar g = 0; g < NTMR; g++) begin : g_tmr
         smon_timer #(.CNT_W(CNT_W)) u_tmr (
            .clk(clk), .rst_n(rst_n), .restart(tmr_rst[g]), .cnt(tcnt[g])
         );
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                    armed_q <= 1'b0;
      else if (!sel_now)             armed_q <= 1'b0;
      else if (addr_chg)             armed_q <= 1'b1;
   end

   always_comb begin
      hit           = '0;
      hit[RULE_WP]  = win_end && (tcnt[TMR_WIN] < L_WP);
      hit[RULE_CW]  = win_end && (sel_rise || tcnt[TMR_SEL] < L_CW);
      hit[RULE_AW]  = win_end && (addr_chg || tcnt[TMR_ADR] < L_AW);
      hit[RULE_DW]  = win_end && (data_chg || tcnt[TMR_DAT] < L_DW);
      hit[RULE_CYC] = addr_chg && sel_now && armed_q && (tcnt[TMR_ADR] < L_CYC);
      hit[RULE_AWR] = addr_chg && win_hold;
   end

   smon_flags #(.NR(NRULE), .CODE_W(CODE_W)) u_flg (
      .clk(clk), .rst_n(rst_n), .clr(clr), .hit(hit),
      .viol(flags), .stb(flag_stb), .code(flag_code)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cycles <= '0;
      else        cycles <= cycles + CYC_W'(win_end) + CYC_W'(addr_chg && read_now);
   end

   assert_awr_sel_R7: assert property (@(posedge clk) disable iff (!rst_n)
      hit[RULE_AWR] |-> sel_now);

   assert_cyc_armed_R6: assert property (@(posedge clk) disable iff (!rst_n)
      hit[RULE_CYC] |-> $past(sel_now));

   assert_cnt_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (!win_end && !(addr_chg && read_now)) |=> $stable(cycles));

   assert_end_rules_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !win_end |-> (hit[RULE_DW:RULE_WP] == '0));

endmodule

// File: tb/sim_sram_bus_monitor.sv
module sim_sram_bus_monitor;

   localparam int CLK_P  = 10;
   localparam int WD_LIM = 150000;
   localparam int P_WP = 5, P_CW = 6, P_AW = 6, P_DW = 3, P_CYC = 7;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        clr = 1'b0;
   logic        sel_n = 1'b1, sel = 1'b0, oe_n = 1'b1, we_n = 1'b1;
   logic [16:0] addr = '0;
   logic [7:0]  data = '0;
   logic [5:0]  flags;
   logic        flag_stb;
   logic [2:0]  flag_code;
   logic [15:0] cycles;

   int total = 0, bad = 0, wd = 0;
   int nstb = 0;
   int cmask = 0;
   int exp_cyc = 0;
   int key = 0;
   bit done = 0;

   sram_bus_monitor #(.T_WP(P_WP), .T_CW(P_CW), .T_AW(P_AW), .T_DW(P_DW),
                      .T_CYC(P_CYC)) u0 (
      .clk(clk), .rst_n(rst_n), .clr(clr),
      .bus_sel_n(sel_n), .bus_sel(sel), .bus_oe_n(oe_n), .bus_we_n(we_n),
      .bus_addr(addr), .bus_data(data),
      .flags(flags), .flag_stb(flag_stb), .flag_code(flag_code), .cycles(cycles)
   );

   always #(CLK_P / 2) clk = ~clk;

   always @(negedge clk) begin
      if (flag_stb) begin
         nstb++;
         cmask = cmask | (1 << flag_code);
      end
   end

   always @(posedge clk) begin
      wd++;
      if (wd == WD_LIM && !done) begin
         bad++;
         total++;
         $display("FAIL R1 watchdog act=%0d exp<%0d", wd, WD_LIM);
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   task automatic chk(input string tag, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
      end
   endtask

   task automatic clear_all();
      @(negedge clk) clr = 1'b1;
      @(negedge clk) clr = 1'b0;
      @(negedge clk);
      nstb = 0;
      cmask = 0;
   endtask

   task automatic do_write(input int sl, input int wl, input int al, input int dl,
                           input bit collide);
      int lead;
      int wlen;
      int endm;
      int lowest;
      bit awr;
      lead = sl;
      if (wl > lead) lead = wl;
      if (al > lead) lead = al;
      if (dl > lead) lead = dl;
      wlen = (sl < wl) ? sl : wl;
      clear_all();
      key++;
      for (int t = lead; t >= 1; t--) begin
         @(negedge clk);
         if (t == sl) begin sel_n = 1'b0; sel = 1'b1; end
         if (t == wl) we_n = 1'b0;
         if (t == al) addr = 17'(key * 3 + 1);
         if (t == dl) data = 8'(key);
      end
      @(negedge clk) we_n = 1'b1;
      if (collide) begin
         @(negedge clk) clr = 1'b1;
         @(negedge clk) clr = 1'b0;
      end else begin
         @(negedge clk);
      end
      @(negedge clk) begin sel_n = 1'b1; sel = 1'b0; end
      repeat (4) @(negedge clk);
      exp_cyc++;
      endm = 0;
      if (wlen < P_WP) endm |= 1;
      if (sl < P_CW)   endm |= 2;
      if (al < P_AW)   endm |= 4;
      if (dl < P_DW)   endm |= 8;
      awr = (al < wlen);
      lowest = 0;
      for (int i = 3; i >= 0; i--) if (endm[i]) lowest = i;
      chk("R2 pulse flag",   int'(flags[0]), endm & 1);
      chk("R3 select flag",  int'(flags[1]), (endm >> 1) & 1);
      chk("R4 address flag", int'(flags[2]), (endm >> 2) & 1);
      chk("R5 data flag",    int'(flags[3]), (endm >> 3) & 1);
      chk("R6 no spacing flag in write", int'(flags[4]), 0);
      chk("R7 addr-in-window flag", int'(flags[5]), collide ? 0 : int'(awr));
      chk("R8 strobe count", nstb, (endm != 0 ? 1 : 0) + (awr ? 1 : 0));
      chk("R8 strobe codes", cmask, (endm != 0 ? (1 << lowest) : 0) | (awr ? 32 : 0));
   endtask

   task automatic do_read(input int gap);
      clear_all();
      @(negedge clk) begin sel_n = 1'b0; sel = 1'b1; oe_n = 1'b0; end
      repeat (2) @(negedge clk);
      key++;
      addr = 17'(key * 3 + 1);
      repeat (gap) @(negedge clk);
      key++;
      addr = 17'(key * 3 + 1);
      repeat (3) @(negedge clk);
      sel_n = 1'b1; sel = 1'b0; oe_n = 1'b1;
      repeat (3) @(negedge clk);
      exp_cyc += 2;
      chk("R6 spacing flag", int'(flags[4]), (gap < P_CYC) ? 1 : 0);
      chk("R6 other flags clear", int'(flags & 6'h2F), 0);
      chk("R8 spacing code", cmask, (gap < P_CYC) ? 16 : 0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      chk("R1 flags at reset", int'(flags), 0);
      chk("R1 strobe at reset", int'(flag_stb), 0);
      chk("R1 cycles at reset", int'(cycles), 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      chk("R1 flags after reset", int'(flags), 0);

      for (int wl = 1; wl <= 6; wl++)
         for (int si = 0; si < 2; si++)
            for (int al = 1; al <= 7; al++)
               for (int dl = 1; dl <= 4; dl++)
                  do_write(si ? 7 : wl, wl, al, dl, 1'b0);

      // R2: window opened by the select rather than write enable
      do_write(3, 6, 7, 7, 1'b0);

      // R9: clear at the edge that records the close-time violations
      do_write(7, 2, 1, 4, 1'b1);
      chk("R9 kept flags on collision", int'(flags), 6'b000101);
      clear_all();
      chk("R9 clear empties flags", int'(flags), 0);

      for (int g = 1; g <= 9; g++) do_read(g);

      // R6: deselection between changes disarms the spacing rule
      clear_all();
      @(negedge clk) begin sel_n = 1'b0; sel = 1'b1; oe_n = 1'b0; end
      repeat (2) @(negedge clk);
      key++; addr = 17'(key * 3 + 1);
      @(negedge clk) begin sel_n = 1'b1; sel = 1'b0; end
      @(negedge clk) begin sel_n = 1'b0; sel = 1'b1; end
      @(negedge clk) begin key++; addr = 17'(key * 3 + 1); end
      repeat (3) @(negedge clk);
      sel_n = 1'b1; sel = 1'b0; oe_n = 1'b1;
      repeat (3) @(negedge clk);
      exp_cyc += 2;
      chk("R6 disarmed by deselect", int'(flags), 0);
      chk("R10 cycle total", int'(cycles), exp_cyc);

      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule